// File: doc/BRIEF.md
# Bidirectional Nibble GPIO Bank

This block is a bank of four-bit bidirectional I/O ports for a small microcontroller. Each port holds an output latch and a direction setting, drives its pins through tri-state enables, and returns a read value that comes either from the latch or from the synchronized pin level. A simple synchronous register bus, with separate write and read strobes, reaches every port's data register and direction register. A bit-set or bit-clear is done as a read followed on the next cycle by a write of the modified value.

The first group of ports sets direction per bit. The second group has one direction flag that switches all four pins of the port together. On port 0, bits 3 and 2 read back the live pin level even when they drive. A read-modify-write of port 0 can therefore load an externally forced pin level into those latch bits, and the block reproduces this behaviour faithfully.

Pins are exposed as three vectors: `pin_out` (latch value), `pin_oe` (driver enable) and `pin_in` (resolved pad level). Port k owns bits [4k+3:4k] of each vector.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset every driver enable is 0 (all pins input), every output latch is 0 and `rd_data` is 0; direction registers read back 0.
- R2: A write to a port's data register updates its output latch whatever the direction; an input-mode pin keeps its driver disabled, and the stored value appears on the pin once the pin becomes an output.
- R3: A write takes effect on `pin_out`/`pin_oe` at the clock edge that samples it; without a write both vectors stay unchanged.
- R4: A data read of an input-mode pin returns its level as seen through a two-flop synchronizer: a level applied before a clock edge is first returned by a read issued two cycles later.
- R5: A data read of an ordinary output-mode pin returns the latch bit, even when the pad is held at the opposite level externally, so a read-modify-write leaves that bit unchanged.
- R6: On port 0, bits 3 and 2 return the synchronized pin level also in output mode.
- R7: A read-modify-write of port 0 while bit 2 is an output held low externally writes 0 back into latch bit 2, visible on `pin_out[2]`.
- R8: Ports 0 to NUM_BIT_PORTS-1 have one direction bit per pin: write data bit i sets pin i (1 = output, 0 = input); the register reads back as written.
- R9: The remaining NUM_NIB_PORTS ports use only write data bit 0 as direction for all four pins; the direction register reads back that bit replicated to all four bits.
- R10: `rd_data` is registered: it is loaded at the edge that samples `rd_en` and holds otherwise; a read and a write to the same register in the same cycle return the value before the write.
- R11: Address bit ADDR_W-1 selects the direction register (1) or data register (0); the low bits give the port index. An index at or above the port count reads 0 and its writes change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address: space bit plus port index |
| wr_data | input | 4 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address: space bit plus port index |
| rd_data | output | 4 | Registered read data |
| pin_in | input | 4*NPORTS | Resolved pad levels |
| pin_out | output | 4*NPORTS | Output latch values toward the pads |
| pin_oe | output | 4*NPORTS | Pad driver enables, 1 = driving |

## Verification
A read and a write can both land on the same data register in one cycle, because the two strobes have their own addresses. The bench raises both strobes on port 1 in one cycle and expects the value held before the write, then reads again and expects the new value. The same question arises across cycles in the port-0 hazard, where the read value that the write returns was taken from the pad rather than from the latch. The bench judges this by comparing `pin_out` on port 0 with the result on port 1, where the same sequence leaves the latch intact.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic {
        SPACE_DATA = 1'b0,
        SPACE_DIR  = 1'b1
    } space_e;

    typedef struct packed {
        logic we_data;
        logic we_dir;
        nib_t wdata;
    } port_wr_t;

    // Per bit: drive-and-not-live gives the latch, otherwise the synced pad
    function automatic nib_t pick_read(nib_t dir, nib_t latch, nib_t pad, nib_t live);
        nib_t r;
        for (int i = 0; i < NIB_W; i++)
            r[i] = (dir[i] && !live[i]) ? latch[i] : pad[i];
        return r;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int NPORTS = 12,
    parameter int AW     = 5
) (
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  nib_t          wr_data,
    output port_wr_t      wr_vec [NPORTS]
);
    localparam int IW = AW - 1;

    space_e        space;
    logic [IW-1:0] idx;

    assign space = space_e'(wr_addr[AW-1]);
    assign idx   = wr_addr[IW-1:0];

    for (genvar k = 0; k < NPORTS; k++) begin : g_dec
        logic hit;
        assign hit               = wr_en && (idx == IW'(k));
        assign wr_vec[k].we_data = hit && (space == SPACE_DATA);
        assign wr_vec[k].we_dir  = hit && (space == SPACE_DIR);
        assign wr_vec[k].wdata   = wr_data;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter bit   PER_BIT   = 1'b1,
    parameter nib_t LIVE_MASK = 4'b0000
) (
    input  logic     clk,
    input  logic     rst,
    input  port_wr_t wr,
    input  nib_t     pad_sync,
    output nib_t     pad_out,
    output nib_t     pad_oe,
    output nib_t     data_rd,
    output nib_t     dir_rd
);
    nib_t latch_q;
    nib_t dir;

    always_ff @(posedge clk) begin
        if (rst)             latch_q <= '0;
        else if (wr.we_data) latch_q <= wr.wdata;
    end

    if (PER_BIT) begin : g_bitdir
        nib_t dir_q;
        always_ff @(posedge clk) begin
            if (rst)            dir_q <= '0;
            else if (wr.we_dir) dir_q <= wr.wdata;
        end
        assign dir = dir_q;
    end else begin : g_nibdir
        logic dir_b;
        always_ff @(posedge clk) begin
            if (rst)            dir_b <= 1'b0;
            else if (wr.we_dir) dir_b <= wr.wdata[0];
        end
        assign dir = {NIB_W{dir_b}};
    end

    assign pad_out = latch_q;
    assign pad_oe  = dir;
    assign data_rd = pick_read(dir, latch_q, pad_sync, LIVE_MASK);
    assign dir_rd  = dir;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int   NUM_BIT_PORTS = 8,
    parameter int   NUM_NIB_PORTS = 4,
    parameter nib_t LIVE_MASK0    = 4'b1100
) (
    input  logic                                                 clk,
    input  logic                                                 rst,
    input  logic                                                 wr_en,
    input  logic [$clog2(NUM_BIT_PORTS+NUM_NIB_PORTS):0]         wr_addr,
    input  logic [3:0]                                           wr_data,
    input  logic                                                 rd_en,
    input  logic [$clog2(NUM_BIT_PORTS+NUM_NIB_PORTS):0]         rd_addr,
    output logic [3:0]                                           rd_data,
    input  logic [4*(NUM_BIT_PORTS+NUM_NIB_PORTS)-1:0]           pin_in,
    output logic [4*(NUM_BIT_PORTS+NUM_NIB_PORTS)-1:0]           pin_out,
    output logic [4*(NUM_BIT_PORTS+NUM_NIB_PORTS)-1:0]           pin_oe
);
    localparam int NPORTS = NUM_BIT_PORTS + NUM_NIB_PORTS;
    localparam int IW     = $clog2(NPORTS);
    localparam int AW     = IW + 1;
    localparam int NPINS  = NIB_W * NPORTS;

    port_wr_t         wr_vec [NPORTS];
    nib_t             data_rd [NPORTS];
    nib_t             dir_rd  [NPORTS];
    logic [NPINS-1:0] pin_sync;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_decode #(.NPORTS(NPORTS), .AW(AW)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_vec  (wr_vec)
    );

    for (genvar k = 0; k < NPORTS; k++) begin : g_port
        gpio_port #(
            .PER_BIT   (k < NUM_BIT_PORTS),
            .LIVE_MASK ((k == 0) ? LIVE_MASK0 : nib_t'(0))
        ) u_port (
            .clk      (clk),
            .rst      (rst),
            .wr       (wr_vec[k]),
            .pad_sync (pin_sync[NIB_W*k +: NIB_W]),
            .pad_out  (pin_out[NIB_W*k +: NIB_W]),
            .pad_oe   (pin_oe[NIB_W*k +: NIB_W]),
            .data_rd  (data_rd[k]),
            .dir_rd   (dir_rd[k])
        );
    end

    space_e        rd_space;
    logic [IW-1:0] rd_idx;
    nib_t          rd_next;

    assign rd_space = space_e'(rd_addr[AW-1]);
    assign rd_idx   = rd_addr[IW-1:0];

    always_comb begin
        rd_next = '0;
        for (int k = 0; k < NPORTS; k++) begin
            if (rd_idx == IW'(k))
                rd_next = (rd_space == SPACE_DIR) ? dir_rd[k] : data_rd[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NUM_BIT_PORTS = 8,
    parameter int NUM_NIB_PORTS = 4
) (
    input logic                                          clk,
    input logic                                          rst,
    input logic                                          wr_en,
    input logic [$clog2(NUM_BIT_PORTS+NUM_NIB_PORTS):0]  wr_addr,
    input logic [3:0]                                    wr_data,
    input logic                                          rd_en,
    input logic [3:0]                                    rd_data,
    input logic [4*(NUM_BIT_PORTS+NUM_NIB_PORTS)-1:0]    pin_out,
    input logic [4*(NUM_BIT_PORTS+NUM_NIB_PORTS)-1:0]    pin_oe
);
    localparam int NPORTS = NUM_BIT_PORTS + NUM_NIB_PORTS;
    localparam int IW     = $clog2(NPORTS);
    localparam int AW     = IW + 1;
    localparam int NIBP   = NUM_BIT_PORTS;

    logic wr_dir_p0, wr_dat_p0, wr_dir_nib, wr_bad;
    assign wr_dir_p0  = wr_en && (wr_addr == {1'b1, IW'(0)});
    assign wr_dat_p0  = wr_en && (wr_addr == {1'b0, IW'(0)});
    assign wr_dir_nib = wr_en && (wr_addr == {1'b1, IW'(NIBP)});
    assign wr_bad     = wr_en && (int'(wr_addr[IW-1:0]) >= NPORTS);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && pin_out == '0 && rd_data == '0)); // R1

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_dat_p0 |=> (pin_out[3:0] == $past(wr_data))); // R2

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(pin_oe) && $stable(pin_out))); // R3

    AST_DIR_BITWISE: assert property (@(posedge clk) disable iff (rst)
        wr_dir_p0 |=> (pin_oe[3:0] == $past(wr_data))); // R8

    AST_DIR_NIBBLE: assert property (@(posedge clk) disable iff (rst)
        wr_dir_nib |=> (pin_oe[4*NIBP +: 4] == {4{$past(wr_data[0])}})); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data)); // R10

    AST_BAD_INDEX: assert property (@(posedge clk) disable iff (rst)
        wr_bad |=> ($stable(pin_oe) && $stable(pin_out))); // R11
endmodule

bind gpio_bank gpio_bank_chk #(
    .NUM_BIT_PORTS (NUM_BIT_PORTS),
    .NUM_NIB_PORTS (NUM_NIB_PORTS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
    localparam int NB   = 8;
    localparam int NN   = 4;
    localparam int NP   = NB + NN;
    localparam int AW   = $clog2(NP) + 1;
    localparam int NPIN = 4 * NP;
    localparam logic [AW-1:0] DIRB = AW'(1) << (AW - 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [3:0]      wr_data = '0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [3:0]      rd_data;
    logic [NPIN-1:0] pin_in, pin_out, pin_oe;
    logic [NPIN-1:0] ext_val = '0;
    logic [NPIN-1:0] ext_force = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // Pad resolver: external force overrides our driver; undriven pads take ext_val
    assign pin_in = (pin_oe & ~ext_force & pin_out) | ((~pin_oe | ext_force) & ext_val);

    gpio_bank #(.NUM_BIT_PORTS(NB), .NUM_NIB_PORTS(NN)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    typedef struct {
        logic [3:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    logic     rd_seen = 1'b0;

    function automatic void check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    // Monitor: one result per sampled read strobe, compared off the edge
    always @(posedge clk) rd_seen <= rd_en && !rst;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard underflow actual=%h expected=none", rd_data);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.tag, 64'(rd_data), 64'(it.exp));
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [3:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [3:0] exp, input string tag);
        rd_item_t it;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NPIN-1:0] oe_save, out_save;
        idle(3);
        rst = 1'b0;
        // R1 reset state
        check("R1 oe", 64'(pin_oe), 64'(0));
        check("R1 out", 64'(pin_out), 64'(0));
        check("R1 rd_data", 64'(rd_data), 64'(0));
        idle(1);
        rd(DIRB | AW'(0), 4'b0000, "R1 dir readback");

        // R8 per-bit direction on port 1
        wr(DIRB | AW'(1), 4'b0101);
        check("R8 oe port1", 64'(pin_oe[7:4]), 64'(4'b0101));
        rd(DIRB | AW'(1), 4'b0101, "R8 dir readback");

        // R9 nibble direction on port NB
        wr(DIRB | AW'(NB), 4'b0001);
        check("R9 oe all set", 64'(pin_oe[4*NB +: 4]), 64'(4'b1111));
        rd(DIRB | AW'(NB), 4'b1111, "R9 dir replicated");
        wr(DIRB | AW'(NB), 4'b1110);
        check("R9 only bit0 used", 64'(pin_oe[4*NB +: 4]), 64'(4'b0000));
        rd(DIRB | AW'(NB), 4'b0000, "R9 dir cleared");

        // R2 latch write on input-mode port 2
        wr(AW'(2), 4'b1010);
        check("R2 still input", 64'(pin_oe[11:8]), 64'(0));
        check("R2 pad undisturbed", 64'(pin_in[11:8]), 64'(0));
        idle(3);
        rd(AW'(2), 4'b0000, "R2 input reads pad");
        wr(DIRB | AW'(2), 4'b1111);
        check("R2 latch shows on enable", 64'(pin_out[11:8]), 64'(4'b1010));
        check("R3 oe after dir write", 64'(pin_oe[11:8]), 64'(4'b1111));
        check("R2 pad driven", 64'(pin_in[11:8]), 64'(4'b1010));

        // R4 synchronizer lag on input port 3
        ext_val[15:12] = 4'b0110;
        rd(AW'(3), 4'b0000, "R4 lag cycle 1");
        rd(AW'(3), 4'b0000, "R4 lag cycle 2");
        rd(AW'(3), 4'b0110, "R4 level arrives");

        // R3/R5 ordinary output port 1 with bit 2 forced low externally
        wr(DIRB | AW'(1), 4'b1111);
        wr(AW'(1), 4'b1100);
        check("R3 out port1", 64'(pin_out[7:4]), 64'(4'b1100));
        ext_force[6] = 1'b1; ext_val[6] = 1'b0;
        idle(3);
        rd(AW'(1), 4'b1100, "R5 latch read despite pad");
        wr(AW'(1), 4'b1100 & ~4'b1000);
        ext_force[6] = 1'b0;
        check("R5 rmw keeps bit2", 64'(pin_out[7:4]), 64'(4'b0100));

        // R6/R7 live bits on port 0
        wr(DIRB | AW'(0), 4'b1100);
        wr(AW'(0), 4'b1100);
        ext_force[2] = 1'b1; ext_val[3:0] = 4'b0000;
        idle(3);
        rd(AW'(0), 4'b1000, "R6 live pad level");
        wr(AW'(0), 4'b1000 & ~4'b1000);
        ext_force[2] = 1'b0;
        check("R7 bit2 latch overwritten", 64'(pin_out[3:0]), 64'(4'b0000));
        idle(3);
        rd(AW'(0), 4'b0000, "R6 pads follow latch");

        // R10 read and write of port 1 in the same cycle
        begin
            rd_item_t it;
            it.exp = 4'b0100; it.tag = "R10 same-cycle old value";
            sb_q.push_back(it);
            wr_en = 1'b1; wr_addr = AW'(1); wr_data = 4'b0011;
            rd_en = 1'b1; rd_addr = AW'(1);
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
        end
        idle(2);
        check("R10 rd_data holds", 64'(rd_data), 64'(4'b0100));
        rd(AW'(1), 4'b0011, "R10 new value");

        // R11 out-of-range port index
        rd(AW'(13), 4'b0000, "R11 bad index reads 0");
        oe_save = pin_oe; out_save = pin_out;
        wr(DIRB | AW'(14), 4'b1111);
        wr(AW'(13), 4'b1111);
        check("R11 oe unchanged", 64'(pin_oe), 64'(oe_save));
        check("R11 out unchanged", 64'(pin_out), 64'(out_save));

        idle(3);
        if (sb_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule